// File: doc/BRIEF.md
# Queue Head Overlay Update Unit

This block holds the working transfer-state area of one host-controller queue head and applies the per-field update rules to it. When a new transfer descriptor has been fetched, the overlay strobe merges the descriptor's fields into the working area. Each field follows its own rule. Some fields are inherited from the descriptor. The ping/error bit is kept for high-speed endpoints. The split-transaction progress fields are cleared. The NAK counter is reloaded from the queue head's constant reload value.

While a descriptor is executing, result pulses update the working area. NAK and NYET responses count the NAK counter down. Errors count the error counter down. ACKs flip the data toggle. An advance strobe retires the descriptor and presents the error counter and toggle as write-back values for one cycle. A pulse marking the first visit of the queue head in a fresh pass of the reclamation list reloads the NAK counter.

The control is a three-state machine:
- ST_IDLE: no descriptor is held.
- ST_ACTIVE: a descriptor is executing.
- ST_RETIRE: a one-cycle write-back state.

Its transitions:
- load: ST_IDLE to ST_ACTIVE on an overlay.
- reload: ST_ACTIVE to ST_ACTIVE on an overlay.
- advance: ST_ACTIVE to ST_RETIRE on an advance without an overlay.
- drain: ST_RETIRE to ST_IDLE.
- chain: ST_RETIRE to ST_ACTIVE on an overlay.

Top module: `qh_overlay_unit`

## Requirements
- R1: While reset is asserted, every output is zero: ovl_active and wb_valid are 0, and all overlay fields are 0.
- R2: On an overlay, ovl_ioc, ovl_cerr and ovl_sbytes take the descriptor's values, and ovl_cprog and ovl_ftag become zero. The outputs show this from the cycle after the strobe.
- R3: On an overlay with qh_dtc=1, ovl_toggle takes dsc_toggle. With qh_dtc=0, ovl_toggle keeps its previous value.
- R4: On an overlay with qh_eps=2'b10 (high speed), ovl_ping_err keeps its value. For any other qh_eps value it takes dsc_ping_err.
- R5: ovl_nakcnt is loaded with qh_nak_reload on every overlay. It is also loaded on every cycle that reclaim_first is high, in any state.
- R6: In ST_ACTIVE, a res_nak or res_nyet pulse decrements ovl_nakcnt by one. The counter stops at zero, so a reload value of zero disables NAK counting.
- R7: In ST_ACTIVE, res_err decrements ovl_cerr and stops at zero, and res_ack inverts ovl_toggle.
- R8: An advance in ST_ACTIVE without an overlay leads to ST_RETIRE for exactly one cycle. In that cycle wb_valid=1, and wb_cerr and wb_toggle show the error counter and toggle that include that cycle's results. The state then becomes ST_IDLE, where ovl_active=0.
- R9: An overlay takes priority over result pulses, advance and reclaim_first arriving in the same cycle. Those inputs then have no effect.
- R10: In ST_IDLE and ST_RETIRE, the result pulses and adv_stb change no overlay field and no state.
- R11: When reclaim_first and a NAK/NYET pulse coincide without an overlay, the reload wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ovl_stb | input | 1 | Merge the incoming descriptor this cycle |
| dsc_ioc | input | 1 | Descriptor interrupt-on-complete |
| dsc_toggle | input | 1 | Descriptor data toggle |
| dsc_cerr | input | 2 | Descriptor error counter |
| dsc_ping_err | input | 1 | Descriptor ping-state/error bit |
| dsc_sbytes | input | 7 | Descriptor split byte count |
| adv_stb | input | 1 | Retire the current descriptor |
| res_ack | input | 1 | Transaction ended with ACK |
| res_nak | input | 1 | Transaction ended with NAK |
| res_nyet | input | 1 | Transaction ended with NYET |
| res_err | input | 1 | Transaction ended with an error |
| reclaim_first | input | 1 | First visit in a new reclamation pass |
| qh_nak_reload | input | 4 | NAK counter reload value |
| qh_eps | input | 2 | Endpoint speed, 2'b10 is high speed |
| qh_dtc | input | 1 | Toggle taken from descriptor when 1 |
| ovl_active | output | 1 | State is ST_ACTIVE |
| ovl_ioc | output | 1 | Working interrupt-on-complete |
| ovl_toggle | output | 1 | Working data toggle |
| ovl_cerr | output | 2 | Working error counter |
| ovl_ping_err | output | 1 | Working ping-state/error bit |
| ovl_cprog | output | 8 | Split complete-progress mask |
| ovl_ftag | output | 5 | Split frame tag |
| ovl_sbytes | output | 7 | Split byte count |
| ovl_nakcnt | output | 4 | NAK counter |
| wb_valid | output | 1 | Write-back values valid (ST_RETIRE) |
| wb_cerr | output | 2 | Error counter to write back |
| wb_toggle | output | 1 | Toggle to write back |

## Verification
Every field sits in a register one edge from its inputs. A wrong merge rule or a wrong counter step therefore shows on the matching output in the cycle after the stimulus. A misdecoded state shows on ovl_active or wb_valid in that same cycle. A lost result pulse in ST_ACTIVE, or a stray one in ST_IDLE/ST_RETIRE, appears on ovl_nakcnt, ovl_cerr or ovl_toggle right away. It also persists into the write-back values. The bench runs a reference model in parallel and compares every output after every edge, so any divergence is reported on the cycle it first appears.

// File: rtl/qh_ovl_pkg.sv
package qh_ovl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_RETIRE = 2'd2
    } ovl_state_e;

    // endpoint speed code for high speed
    localparam logic [1:0] EPS_HIGH = 2'b10;
endpackage

// File: rtl/qh_ovl_fsm.sv
module qh_ovl_fsm
    import qh_ovl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ovl_stb,
    input  logic adv_stb,
    output logic active_o,
    output logic exec_en_o,
    output logic wb_valid_o
);
    ovl_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (ovl_stb) state_d = ST_ACTIVE;               // load
            ST_ACTIVE: begin
                if (ovl_stb)      state_d = ST_ACTIVE;                 // reload
                else if (adv_stb) state_d = ST_RETIRE;                 // advance
            end
            ST_RETIRE: state_d = ovl_stb ? ST_ACTIVE : ST_IDLE;        // chain / drain
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        active_o   = 1'b0;
        wb_valid_o = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_ACTIVE: active_o   = 1'b1;
            ST_RETIRE: wb_valid_o = 1'b1;
            default:   ;
        endcase
        // results apply only to an executing descriptor not being replaced
        exec_en_o = active_o && !ovl_stb;
    end

    p_retire_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid_o |=> !wb_valid_o);
    p_wb_after_adv_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && adv_stb && !ovl_stb) |=> wb_valid_o);
    p_overlay_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ovl_stb |=> active_o);
endmodule

// File: rtl/qh_nak_counter.sv
module qh_nak_counter #(
    parameter int NAK_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ovl_stb,
    input  logic             reclaim_first,
    input  logic             exec_en,
    input  logic             res_nak,
    input  logic             res_nyet,
    input  logic [NAK_W-1:0] reload,
    output logic [NAK_W-1:0] cnt_o
);
    localparam logic [NAK_W-1:0] ZERO = '0;

    logic [NAK_W-1:0] cnt_q;
    logic             load, step;

    assign load = ovl_stb || reclaim_first;
    assign step = exec_en && (res_nak || res_nyet) && (cnt_q != ZERO);

    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= ZERO;
        else if (load) cnt_q <= reload;
        else if (step) cnt_q <= cnt_q - 1'b1;
    end

    assign cnt_o = cnt_q;

    p_nak_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ovl_stb |=> cnt_o == $past(reload));
    p_nak_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == ZERO && !ovl_stb && !reclaim_first) |=> cnt_o == ZERO);
    p_nak_no_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovl_stb && !reclaim_first) |=> cnt_o <= $past(cnt_o));
    p_reclaim_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reclaim_first && res_nak) |=> cnt_o == $past(reload));
endmodule

// File: rtl/qh_ovl_fields.sv
module qh_ovl_fields
    import qh_ovl_pkg::*;
#(
    parameter int CERR_W  = 2,
    parameter int CPROG_W = 8,
    parameter int FTAG_W  = 5,
    parameter int SB_W    = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ovl_stb,
    input  logic               exec_en,
    input  logic               in_ioc,
    input  logic               in_toggle,
    input  logic [CERR_W-1:0]  in_cerr,
    input  logic               in_ping,
    input  logic [SB_W-1:0]    in_sbytes,
    input  logic [1:0]         qh_eps,
    input  logic               qh_dtc,
    input  logic               res_ack,
    input  logic               res_err,
    output logic               ioc_o,
    output logic               toggle_o,
    output logic [CERR_W-1:0]  cerr_o,
    output logic               ping_o,
    output logic [CPROG_W-1:0] cprog_o,
    output logic [FTAG_W-1:0]  ftag_o,
    output logic [SB_W-1:0]    sbytes_o
);
    localparam logic [CERR_W-1:0] CERR_ZERO = '0;

    logic               ioc_q, tog_q, ping_q;
    logic [CERR_W-1:0]  cerr_q;
    logic [CPROG_W-1:0] cprog_q;
    logic [FTAG_W-1:0]  ftag_q;
    logic [SB_W-1:0]    sb_q;

    // inherit rule: ioc and split byte count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ioc_q <= 1'b0;
            sb_q  <= '0;
        end else if (ovl_stb) begin
            ioc_q <= in_ioc;
            sb_q  <= in_sbytes;
        end
    end

    // clear rule: split progress fields (advanced only by split execution)
    always_ff @(posedge clk) begin
        if (!rst_n || ovl_stb) begin
            cprog_q <= '0;
            ftag_q  <= '0;
        end
    end

    // error counter: copied on overlay, decremented by errors
    always_ff @(posedge clk) begin
        if (!rst_n)                                         cerr_q <= CERR_ZERO;
        else if (ovl_stb)                                   cerr_q <= in_cerr;
        else if (exec_en && res_err && cerr_q != CERR_ZERO) cerr_q <= cerr_q - 1'b1;
    end

    // toggle: conditional inherit, flipped by ACK
    always_ff @(posedge clk) begin
        if (!rst_n)                  tog_q <= 1'b0;
        else if (ovl_stb) begin
            if (qh_dtc)              tog_q <= in_toggle;
        end else if (exec_en && res_ack) tog_q <= ~tog_q;
    end

    // ping/error: preserved for high speed, inherited otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)                                ping_q <= 1'b0;
        else if (ovl_stb && qh_eps != EPS_HIGH)    ping_q <= in_ping;
    end

    assign ioc_o    = ioc_q;
    assign toggle_o = tog_q;
    assign cerr_o   = cerr_q;
    assign ping_o   = ping_q;
    assign cprog_o  = cprog_q;
    assign ftag_o   = ftag_q;
    assign sbytes_o = sb_q;

    p_ioc_inherit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ovl_stb |=> ioc_o == $past(in_ioc));
    p_cerr_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ovl_stb |=> cerr_o == $past(in_cerr));
    p_toggle_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ovl_stb && !qh_dtc) |=> toggle_o == $past(toggle_o));
    p_ping_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ovl_stb && qh_eps == EPS_HIGH) |=> $stable(ping_o));
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovl_stb && !exec_en) |=> ($stable(toggle_o) && $stable(cerr_o)));
endmodule

// File: rtl/qh_overlay_unit.sv
module qh_overlay_unit #(
    parameter int NAK_W   = 4,
    parameter int CERR_W  = 2,
    parameter int CPROG_W = 8,
    parameter int FTAG_W  = 5,
    parameter int SB_W    = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ovl_stb,
    input  logic               dsc_ioc,
    input  logic               dsc_toggle,
    input  logic [CERR_W-1:0]  dsc_cerr,
    input  logic               dsc_ping_err,
    input  logic [SB_W-1:0]    dsc_sbytes,
    input  logic               adv_stb,
    input  logic               res_ack,
    input  logic               res_nak,
    input  logic               res_nyet,
    input  logic               res_err,
    input  logic               reclaim_first,
    input  logic [NAK_W-1:0]   qh_nak_reload,
    input  logic [1:0]         qh_eps,
    input  logic               qh_dtc,
    output logic               ovl_active,
    output logic               ovl_ioc,
    output logic               ovl_toggle,
    output logic [CERR_W-1:0]  ovl_cerr,
    output logic               ovl_ping_err,
    output logic [CPROG_W-1:0] ovl_cprog,
    output logic [FTAG_W-1:0]  ovl_ftag,
    output logic [SB_W-1:0]    ovl_sbytes,
    output logic [NAK_W-1:0]   ovl_nakcnt,
    output logic               wb_valid,
    output logic [CERR_W-1:0]  wb_cerr,
    output logic               wb_toggle
);
    logic exec_en;

    qh_ovl_fsm i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ovl_stb    (ovl_stb),
        .adv_stb    (adv_stb),
        .active_o   (ovl_active),
        .exec_en_o  (exec_en),
        .wb_valid_o (wb_valid)
    );

    qh_ovl_fields #(
        .CERR_W (CERR_W), .CPROG_W (CPROG_W), .FTAG_W (FTAG_W), .SB_W (SB_W)
    ) i_fields (
        .clk       (clk),
        .rst_n     (rst_n),
        .ovl_stb   (ovl_stb),
        .exec_en   (exec_en),
        .in_ioc    (dsc_ioc),
        .in_toggle (dsc_toggle),
        .in_cerr   (dsc_cerr),
        .in_ping   (dsc_ping_err),
        .in_sbytes (dsc_sbytes),
        .qh_eps    (qh_eps),
        .qh_dtc    (qh_dtc),
        .res_ack   (res_ack),
        .res_err   (res_err),
        .ioc_o     (ovl_ioc),
        .toggle_o  (ovl_toggle),
        .cerr_o    (ovl_cerr),
        .ping_o    (ovl_ping_err),
        .cprog_o   (ovl_cprog),
        .ftag_o    (ovl_ftag),
        .sbytes_o  (ovl_sbytes)
    );

    qh_nak_counter #(.NAK_W (NAK_W)) i_nak (
        .clk           (clk),
        .rst_n         (rst_n),
        .ovl_stb       (ovl_stb),
        .reclaim_first (reclaim_first),
        .exec_en       (exec_en),
        .res_nak       (res_nak),
        .res_nyet      (res_nyet),
        .reload        (qh_nak_reload),
        .cnt_o         (ovl_nakcnt)
    );

    // write-back values mirror the working fields; valid only in ST_RETIRE
    assign wb_cerr   = ovl_cerr;
    assign wb_toggle = ovl_toggle;

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!ovl_active && !wb_valid && ovl_nakcnt == '0 && ovl_cerr == '0));
endmodule

// File: tb/test_qh_overlay_unit.sv
module test_qh_overlay_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ovl_stb = 0, adv_stb = 0, res_ack = 0, res_nak = 0, res_nyet = 0;
    logic       res_err = 0, reclaim_first = 0;
    logic       dsc_ioc = 0, dsc_toggle = 0, dsc_ping_err = 0, qh_dtc = 0;
    logic [1:0] dsc_cerr = 0, qh_eps = 0;
    logic [6:0] dsc_sbytes = 0;
    logic [3:0] qh_nak_reload = 0;
    logic       ovl_active, ovl_ioc, ovl_toggle, ovl_ping_err, wb_valid, wb_toggle;
    logic [1:0] ovl_cerr, wb_cerr;
    logic [7:0] ovl_cprog;
    logic [4:0] ovl_ftag;
    logic [6:0] ovl_sbytes;
    logic [3:0] ovl_nakcnt;

    int n_chk = 0, n_bad = 0;
    int m_state = 0, m_cerr = 0, m_sb = 0, m_nak = 0;
    bit m_ioc = 0, m_tog = 0, m_ping = 0;

    always #10 clk = ~clk;

    qh_overlay_unit i_qh_overlay_unit (.*);

    task automatic cmp(string tag, string nm, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, nm, act, exp);
        end
    endtask

    task automatic cmp_all();
        cmp("R8", "ovl_active", int'(ovl_active), int'(m_state == 1));
        cmp("R8", "wb_valid", int'(wb_valid), int'(m_state == 2));
        cmp("R2", "ovl_ioc", int'(ovl_ioc), int'(m_ioc));
        cmp("R2", "ovl_sbytes", int'(ovl_sbytes), m_sb);
        cmp("R2", "ovl_cprog", int'(ovl_cprog), 0);
        cmp("R2", "ovl_ftag", int'(ovl_ftag), 0);
        cmp("R2/R7", "ovl_cerr", int'(ovl_cerr), m_cerr);
        cmp("R3/R7", "ovl_toggle", int'(ovl_toggle), int'(m_tog));
        cmp("R4", "ovl_ping_err", int'(ovl_ping_err), int'(m_ping));
        cmp("R5/R6", "ovl_nakcnt", int'(ovl_nakcnt), m_nak);
        cmp("R8", "wb_cerr", int'(wb_cerr), m_cerr);
        cmp("R8", "wb_toggle", int'(wb_toggle), int'(m_tog));
    endtask

    // drive at a falling edge, predict, pass one rising edge, compare
    task automatic cyc(bit ovl, bit adv = 0, bit ack = 0, bit nak = 0,
                       bit nyet = 0, bit err = 0, bit recl = 0);
        bit act;
        ovl_stb = ovl; adv_stb = adv; res_ack = ack; res_nak = nak;
        res_nyet = nyet; res_err = err; reclaim_first = recl;
        act = (m_state == 1);
        if (ovl) begin
            m_ioc = dsc_ioc; m_cerr = int'(dsc_cerr); m_sb = int'(dsc_sbytes);
            if (qh_dtc) m_tog = dsc_toggle;
            if (qh_eps != 2'b10) m_ping = dsc_ping_err;
            m_nak = int'(qh_nak_reload);
            m_state = 1;
        end else begin
            if (recl) m_nak = int'(qh_nak_reload);
            else if (act && (nak || nyet) && m_nak > 0) m_nak--;
            if (act) begin
                if (err && m_cerr > 0) m_cerr--;
                if (ack) m_tog = !m_tog;
            end
            if (act && adv) m_state = 2;
            else if (m_state == 2) m_state = 0;
        end
        @(negedge clk);
        ovl_stb = 0; adv_stb = 0; res_ack = 0; res_nak = 0;
        res_nyet = 0; res_err = 0; reclaim_first = 0;
        cmp_all();
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        cmp("R1", "ovl_active", int'(ovl_active), 0);
        cmp("R1", "wb_valid", int'(wb_valid), 0);
        cmp("R1", "ovl_nakcnt", int'(ovl_nakcnt), 0);
        cmp("R1", "ovl_cerr", int'(ovl_cerr), 0);
        cmp("R1", "ovl_toggle", int'(ovl_toggle), 0);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_all();

        // R2 R3 R4: sweep of merge rules
        for (int dtc = 0; dtc < 2; dtc++)
          for (int eps = 0; eps < 4; eps++)
            for (int pt = 0; pt < 2; pt++)
              for (int pp = 0; pp < 2; pp++)
                for (int nt = 0; nt < 2; nt++)
                  for (int np = 0; np < 2; np++) begin
                      qh_dtc = 1; qh_eps = 2'd0;
                      dsc_toggle = pt[0]; dsc_ping_err = pp[0];
                      cyc(1);
                      qh_dtc = dtc[0]; qh_eps = eps[1:0];
                      dsc_toggle = nt[0]; dsc_ping_err = np[0];
                      dsc_ioc = nt[0] ^ np[0]; dsc_cerr = eps[1:0];
                      dsc_sbytes = 7'(eps * 7 + nt * 3 + np);
                      qh_nak_reload = 4'(eps * 3 + dtc);
                      cyc(1);
                  end

        // R5 R6: NAK counting for every reload value, including zero
        qh_eps = 2'd0; qh_dtc = 1;
        for (int rl = 0; rl < 16; rl++) begin
            qh_nak_reload = 4'(rl);
            cyc(1);
            for (int k = 0; k < 18; k++) cyc(0, 0, 0, k % 2 == 0, k % 2 == 1);
            cyc(0, 0, 0, 0, 0, 0, 1);
            cmp("R5", "reclaim reload", int'(ovl_nakcnt), rl);
        end

        // R11: reload beats a coincident NAK
        qh_nak_reload = 4'd9;
        cyc(1);
        cyc(0, 0, 0, 1); cyc(0, 0, 0, 1);
        cyc(0, 0, 0, 1, 0, 0, 1);
        cmp("R11", "ovl_nakcnt", int'(ovl_nakcnt), 9);

        // R7: error counting and ACK toggling
        for (int c = 0; c < 4; c++) begin
            dsc_cerr = 2'(c);
            cyc(1);
            for (int k = 0; k < 5; k++) cyc(0, 0, k % 2 == 1, 0, 0, 1);
            cmp("R7", "cerr floor", int'(ovl_cerr), 0);
        end

        // R8: advance and write-back
        dsc_cerr = 2'd3; dsc_toggle = 0;
        cyc(1);
        cyc(0, 0, 1, 0, 0, 1);
        cyc(0, 1, 0, 0, 0, 1);
        cmp("R8", "wb_valid", int'(wb_valid), 1);
        cmp("R8", "wb_cerr", int'(wb_cerr), 1);
        cmp("R8", "wb_toggle", int'(wb_toggle), 1);
        // R10: pulses in ST_RETIRE are ignored
        cyc(0, 1, 1, 1, 1, 1);
        cmp("R10", "ovl_active", int'(ovl_active), 0);
        cmp("R10", "ovl_cerr", int'(ovl_cerr), 1);
        cmp("R10", "ovl_toggle", int'(ovl_toggle), 1);
        // R10: pulses in ST_IDLE are ignored
        for (int k = 0; k < 4; k++) cyc(0, 1, k % 2 == 0, 1, 1, 1);
        cmp("R10", "idle nakcnt", int'(ovl_nakcnt), int'(qh_nak_reload));
        cmp("R10", "idle state", int'(ovl_active), 0);

        // R9: overlay wins over everything in the same cycle
        qh_nak_reload = 4'd6;
        cyc(1);
        cyc(0, 0, 0, 1);
        dsc_cerr = 2'd2; qh_nak_reload = 4'd12;
        cyc(1, 1, 1, 1, 1, 1, 0);
        cmp("R9", "ovl_active", int'(ovl_active), 1);
        cmp("R9", "ovl_nakcnt", int'(ovl_nakcnt), 12);
        cmp("R9", "ovl_cerr", int'(ovl_cerr), 2);
        // chained overlay straight out of ST_RETIRE
        cyc(0, 1);
        cyc(1);
        cmp("R8", "chain active", int'(ovl_active), 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule